// File: doc/BRIEF.md
# Minor/Major Loop DMA Channel

A single DMA channel that copies data between memory-mapped locations. Its behaviour is set by a descriptor held on configuration inputs: source and destination start addresses, beat sizes set separately for each side, signed per-beat address steps, a byte count per service, signed end-of-pass address corrections and an iteration count. Each accepted hardware request runs one minor loop, which moves the programmed byte count. Each minor loop also lowers an iteration counter by one. When the counter would reach zero, the pass (the major loop) is over. The end-of-pass corrections are then added to both working addresses, the counter reloads and a sticky done flag rises.

One typical use samples a fixed 16-bit peripheral register on every request into a circular RAM array. The source step is 0 and the destination step is +2. At the end of each pass the destination correction is minus the array size, so the write pointer returns to the start of the array. Requests are accepted only while the channel's request-enable bit is set. A request that arrives while a minor loop is running is held and served next. A start with a bad descriptor raises an error flag and performs no access.

The controller has four states. ST_IDLE waits for a pending request. ST_READ fetches source beats until one chunk is full. ST_WRITE drains the chunk to the destination. ST_LOOP_END updates the counter and the addresses. The transitions are named start (IDLE to READ), chunk-full (READ to WRITE), chunk-empty-more (WRITE to READ), chunk-empty-last (WRITE to LOOP_END), retire (LOOP_END to IDLE), reject (IDLE stays IDLE and sets the error flag) and reload (any state to IDLE on cfg_load).

Top module: `dma_loop_channel`

## Requirements
- R1: After reset, mem_req, done, err and erq are all 0.
- R2: erq_set sets the request-enable bit and erq_clr clears it; if both are high in the same cycle, the bit ends up cleared. A hw_req pulse seen while the bit is clear is dropped and causes no memory access.
- R3: Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. A minor loop moves cfg_nbytes in chunks of max(source size, destination size) bytes. For each chunk the channel first performs all source reads of the source size, then all destination writes of the destination size. Read data is taken from the low bytes of mem_rdata. Bytes are packed in little-endian order: the first byte read is the first byte written, and it sits in bits 7:0 of mem_wdata.
- R4: After each read beat the source address changes by the signed 16-bit cfg_soff. After each write beat the destination address changes by the signed 16-bit cfg_doff. Negative steps walk downward.
- R5: Each completed minor loop lowers the iteration count by one. The minor loop that ends the pass adds the signed cfg_slast to the source address and the signed cfg_dlast to the destination address, reloads the count from cfg_biter and sets done. Before that loop, done stays 0.
- R6: done stays set through later minor loops until a done_clr pulse.
- R7: A request accepted while a minor loop is in progress is served immediately after that loop. Several such requests collapse into a single pending request.
- R8: A start is rejected when any of the following holds: the source address is not a multiple of the source size; the destination address is not a multiple of the destination size; a size code is 3; cfg_nbytes is zero; or cfg_nbytes is not a multiple of the chunk. A rejected start makes no access, sets err and drops the request. While err is set, new requests are ignored.
- R9: cfg_load copies cfg_saddr and cfg_daddr into the working addresses and sets the count to cfg_biter. It also clears done, err and any pending request.
- R10: Once mem_req is raised, it stays high with mem_addr, mem_we, mem_size and mem_wdata unchanged until mem_ack.
- R11: With a 16-bit source of step 0, a 16-bit destination of step +2, a 2-byte minor loop and a destination correction of minus the array size, successive requests write successive array slots. The request after the pass ends writes the first slot again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Pulse: load working addresses and count from the descriptor |
| cfg_saddr | input | AW | Source start address |
| cfg_daddr | input | AW | Destination start address |
| cfg_soff | input | OFW | Signed source step per read beat |
| cfg_doff | input | OFW | Signed destination step per write beat |
| cfg_ssize | input | 2 | Source beat size code |
| cfg_dsize | input | 2 | Destination beat size code |
| cfg_nbytes | input | NBW | Bytes per minor loop |
| cfg_slast | input | AW | Signed source correction at end of pass |
| cfg_dlast | input | AW | Signed destination correction at end of pass |
| cfg_biter | input | ITW | Minor loops per pass |
| erq_set | input | 1 | Set request-enable bit |
| erq_clr | input | 1 | Clear request-enable bit |
| hw_req | input | 1 | Hardware service request |
| done_clr | input | 1 | Clear done flag |
| erq | output | 1 | Request-enable bit |
| done | output | 1 | Pass-complete flag |
| err | output | 1 | Descriptor error flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Access byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data, right-aligned |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | DW | Read data, right-aligned, valid with mem_ack |

## Verification
The embedded assertions watch, on every cycle, the properties that hold at all times. These are: the memory request holding still until it is acknowledged; the error flag keeping the memory port quiet; the packing cursors staying inside the holding buffer; a pending request only appearing while the enable bit was set; and done only rising together with a counter reload. Only the bench scenarios can show the order and content of the accesses. That covers the address walk under zero, positive and negative steps, the byte packing across unequal beat sizes, the wrap to the start of the buffer at the end of a pass, the collapsing of requests that arrive during a busy loop, and the rejection of misaligned descriptors.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ     = 2'd1,
        ST_WRITE    = 2'd2,
        ST_LOOP_END = 2'd3
    } chan_state_e;

    // Beat size code to byte count; an illegal code yields 0.
    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        logic [2:0] n;
        case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            2'd2:    n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic erq_set,
    input  logic erq_clr,
    input  logic hw_req,
    input  logic block,
    input  logic take,
    input  logic flush,
    output logic erq,
    output logic pend
);

    // Clear has priority over set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       erq <= 1'b0;
        else if (erq_clr) erq <= 1'b0;
        else if (erq_set) erq <= 1'b1;
    end

    // A fresh request wins over the consumption of the old one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pend <= 1'b0;
        else if (flush)                      pend <= 1'b0;
        else if (hw_req && erq && !block)    pend <= 1'b1;
        else if (take)                       pend <= 1'b0;
    end

    // R2
    pend_needs_erq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(erq));

endmodule

// File: rtl/dma_iter_ctr.sv
module dma_iter_ctr #(
    parameter int ITW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           done_clr,
    input  logic [ITW-1:0] biter,
    output logic           major,
    output logic           done
);

    logic [ITW-1:0] citer_q;

    assign major = step && (citer_q <= ITW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      citer_q <= '0;
        else if (load)   citer_q <= biter;
        else if (step)   citer_q <= major ? biter : citer_q - ITW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        done <= 1'b0;
        else if (load)     done <= 1'b0;
        else if (major)    done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end

    // R5
    done_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (citer_q == biter));

endmodule

// File: rtl/dma_hold_buf.sv
module dma_hold_buf #(
    parameter int DW = 32,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pos,
    input  logic [2:0]    wr_bytes,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_pos,
    output logic [DW-1:0] rd_data
);

    localparam int NB = DW / 8;

    logic [DW-1:0] store;
    logic [DW-1:0] shifted;

    assign shifted = wr_data << {wr_pos, 3'b000};
    assign rd_data = store >> {rd_pos, 3'b000};

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] lane_q;
        logic       hit;

        assign hit = wr_en
                  && ((PW+1)'(i) >= {1'b0, wr_pos})
                  && ((PW+1)'(i) <  ({1'b0, wr_pos} + (PW+1)'(wr_bytes)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   lane_q <= 8'h00;
            else if (hit) lane_q <= shifted[i*8 +: 8];
        end

        assign store[i*8 +: 8] = lane_q;
    end

endmodule

// File: rtl/dma_loop_channel.sv
module dma_loop_channel
    import dma_chan_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NBW = 16,
    parameter int ITW = 10,
    parameter int OFW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [AW-1:0]  cfg_saddr,
    input  logic [AW-1:0]  cfg_daddr,
    input  logic [OFW-1:0] cfg_soff,
    input  logic [OFW-1:0] cfg_doff,
    input  logic [1:0]     cfg_ssize,
    input  logic [1:0]     cfg_dsize,
    input  logic [NBW-1:0] cfg_nbytes,
    input  logic [AW-1:0]  cfg_slast,
    input  logic [AW-1:0]  cfg_dlast,
    input  logic [ITW-1:0] cfg_biter,
    input  logic           erq_set,
    input  logic           erq_clr,
    input  logic           hw_req,
    input  logic           done_clr,
    output logic           erq,
    output logic           done,
    output logic           err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);

    localparam int NB = DW / 8;
    localparam int PW = $clog2(NB) + 2;

    chan_state_e state_q, state_d;

    logic [AW-1:0]  sa_q, da_q;
    logic [NBW-1:0] left_q;
    logic [PW-1:0]  fill_q, drain_q;
    logic           err_q;

    logic [2:0]     sb, db, chunk;
    logic [PW-1:0]  fill_nx, drain_nx;
    logic [AW-1:0]  soff_x, doff_x;
    logic           misfit, pend, take, go, bad_start;
    logic           rd_beat, wr_beat, rd_full, wr_empty, loop_last;
    logic           step, major;
    logic [DW-1:0]  buf_out;

    assign sb       = size_to_bytes(cfg_ssize);
    assign db       = size_to_bytes(cfg_dsize);
    assign chunk    = (sb > db) ? sb : db;
    assign soff_x   = {{(AW-OFW){cfg_soff[OFW-1]}}, cfg_soff};
    assign doff_x   = {{(AW-OFW){cfg_doff[OFW-1]}}, cfg_doff};
    assign fill_nx  = fill_q + PW'(sb);
    assign drain_nx = drain_q + PW'(db);

    assign misfit = (sb == 3'd0) || (db == 3'd0)
                 || ((sa_q & (AW'(sb) - AW'(1))) != '0)
                 || ((da_q & (AW'(db) - AW'(1))) != '0)
                 || (cfg_nbytes == '0)
                 || ((cfg_nbytes & (NBW'(chunk) - NBW'(1))) != '0);

    assign take      = (state_q == ST_IDLE) && pend && !cfg_load;
    assign go        = take && !misfit;
    assign bad_start = take && misfit;
    assign rd_beat   = (state_q == ST_READ)  && mem_ack;
    assign wr_beat   = (state_q == ST_WRITE) && mem_ack;
    assign rd_full   = (fill_nx == PW'(chunk));
    assign wr_empty  = (drain_nx == PW'(chunk));
    assign loop_last = (left_q == NBW'(db));
    assign step      = (state_q == ST_LOOP_END);
    assign err       = err_q;

    dma_req_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .erq_set (erq_set),
        .erq_clr (erq_clr),
        .hw_req  (hw_req),
        .block   (err_q),
        .take    (take),
        .flush   (cfg_load),
        .erq     (erq),
        .pend    (pend)
    );

    dma_iter_ctr #(.ITW(ITW)) u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .step     (step),
        .done_clr (done_clr),
        .biter    (cfg_biter),
        .major    (major),
        .done     (done)
    );

    dma_hold_buf #(.DW(DW), .PW(PW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rd_beat),
        .wr_pos   (fill_q),
        .wr_bytes (sb),
        .wr_data  (mem_rdata),
        .rd_pos   (drain_q),
        .rd_data  (buf_out)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go) state_d = ST_READ;
            ST_READ:     if (rd_beat && rd_full) state_d = ST_WRITE;
            ST_WRITE:    if (wr_beat && wr_empty)
                             state_d = loop_last ? ST_LOOP_END : ST_READ;
            ST_LOOP_END: state_d = ST_IDLE;
        endcase
        if (cfg_load) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address, count and cursor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sa_q    <= '0;
            da_q    <= '0;
            left_q  <= '0;
            fill_q  <= '0;
            drain_q <= '0;
            err_q   <= 1'b0;
        end else if (cfg_load) begin
            sa_q    <= cfg_saddr;
            da_q    <= cfg_daddr;
            left_q  <= '0;
            fill_q  <= '0;
            drain_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (bad_start) err_q <= 1'b1;
            if (go) begin
                left_q <= cfg_nbytes;
                fill_q <= '0;
            end
            if (rd_beat) begin
                sa_q   <= sa_q + soff_x;
                fill_q <= fill_nx;
                if (rd_full) drain_q <= '0;
            end
            if (wr_beat) begin
                da_q    <= da_q + doff_x;
                drain_q <= drain_nx;
                left_q  <= left_q - NBW'(db);
                if (wr_empty) fill_q <= '0;
            end
            if (major) begin
                sa_q <= sa_q + cfg_slast;
                da_q <= da_q + cfg_dlast;
            end
        end
    end

    // Memory port outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sa_q;
        mem_size  = cfg_ssize;
        mem_wdata = buf_out;
        unique case (state_q)
            ST_READ: begin
                mem_req = 1'b1;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = da_q;
                mem_size = cfg_dsize;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cfg_load) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we)
                 && $stable(mem_size) && $stable(mem_wdata)));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);

    // R3
    cursor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q <= PW'(NB)) && (drain_q <= PW'(NB)));

endmodule

// File: tb/sim_dma_loop_channel.sv
module sim_dma_loop_channel;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_saddr = '0, cfg_daddr = '0, cfg_slast = '0, cfg_dlast = '0;
    logic [15:0] cfg_soff = '0, cfg_doff = '0, cfg_nbytes = '0;
    logic [1:0]  cfg_ssize = '0, cfg_dsize = '0;
    logic [9:0]  cfg_biter = '0;
    logic        erq_set = 1'b0, erq_clr = 1'b0, hw_req = 1'b0, done_clr = 1'b0;
    logic        erq, done, err, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int    checks = 0, errors = 0;
    int    rd_n = 0, exp_rn = 0, stall = 0, wait_n = 0;
    string cur_tag = "R1";
    item_t exp_q[$];
    logic [31:0] m_sa, m_da;
    int    m_citer;

    always #4 clk = ~clk;

    dma_loop_channel u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_saddr(cfg_saddr), .cfg_daddr(cfg_daddr),
        .cfg_soff(cfg_soff), .cfg_doff(cfg_doff),
        .cfg_ssize(cfg_ssize), .cfg_dsize(cfg_dsize),
        .cfg_nbytes(cfg_nbytes), .cfg_slast(cfg_slast), .cfg_dlast(cfg_dlast),
        .cfg_biter(cfg_biter), .erq_set(erq_set), .erq_clr(erq_clr),
        .hw_req(hw_req), .done_clr(done_clr), .erq(erq), .done(done), .err(err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] rd_val(input int n);
        return 32'h9E37_79B9 * (n + 1) + n;
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_n  = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_n < stall) begin
                wait_n++;
            end else begin
                item_t e;
                wait_n  = 0;
                mem_ack = 1'b1;
                if (!mem_we) begin
                    mem_rdata = rd_val(rd_n);
                    rd_n++;
                end
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s unexpected access actual we=%b addr=%h expected none",
                             cur_tag, mem_we, mem_addr);
                end else begin
                    e = exp_q.pop_front();
                    if (e.we !== mem_we || e.addr !== mem_addr || e.size !== mem_size ||
                        (mem_we && ((mem_wdata & size_mask(mem_size)) !== e.data))) begin
                        errors++;
                        $display("FAIL %s access actual we=%b addr=%h size=%0d data=%h expected we=%b addr=%h size=%0d data=%h",
                                 cur_tag, mem_we, mem_addr, mem_size, mem_wdata & size_mask(mem_size),
                                 e.we, e.addr, e.size, e.data);
                    end
                end
            end
        end
    end

    // Driver-side reference: expected accesses of one minor loop (R3, R4, R5)
    task automatic predict_loop();
        int sb, db, ch;
        logic [7:0]  bytes [4];
        logic [31:0] v, d;
        item_t it;
        sb = 1 << cfg_ssize;
        db = 1 << cfg_dsize;
        ch = (sb > db) ? sb : db;
        for (int c = 0; c < int'(cfg_nbytes) / ch; c++) begin
            for (int k = 0; k < ch / sb; k++) begin
                v = rd_val(exp_rn);
                exp_rn++;
                it = '{we: 1'b0, addr: m_sa, size: cfg_ssize, data: 32'h0};
                exp_q.push_back(it);
                for (int b = 0; b < sb; b++) bytes[k*sb + b] = v[b*8 +: 8];
                m_sa = m_sa + sx16(cfg_soff);
            end
            for (int k = 0; k < ch / db; k++) begin
                d = '0;
                for (int b = 0; b < db; b++) d[b*8 +: 8] = bytes[k*db + b];
                it = '{we: 1'b1, addr: m_da, size: cfg_dsize, data: d};
                exp_q.push_back(it);
                m_da = m_da + sx16(cfg_doff);
            end
        end
        m_citer--;
        if (m_citer == 0) begin
            m_sa = m_sa + cfg_slast;
            m_da = m_da + cfg_dlast;
            m_citer = int'(cfg_biter);
        end
    endtask

    task automatic load_cfg(input logic [31:0] sa, input logic [31:0] da,
                            input logic [15:0] so, input logic [15:0] dof,
                            input logic [1:0] ss, input logic [1:0] ds,
                            input logic [15:0] nb, input logic [31:0] sl,
                            input logic [31:0] dl, input logic [9:0] bi);
        @(negedge clk);
        cfg_saddr = sa; cfg_daddr = da; cfg_soff = so; cfg_doff = dof;
        cfg_ssize = ss; cfg_dsize = ds; cfg_nbytes = nb;
        cfg_slast = sl; cfg_dlast = dl; cfg_biter = bi;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_sa = sa; m_da = da; m_citer = int'(bi);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        hw_req = 1'b1;
        @(negedge clk);
        hw_req = 1'b0;
    endtask

    task automatic wait_quiet();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic serve_one();
        pulse_req();
        predict_loop();
        wait_quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 mem_req", {31'b0, mem_req}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 err", {31'b0, err}, 32'd0);
        check("R1 erq", {31'b0, erq}, 32'd0);
        rst_n = 1'b1;

        // R11 configuration: fixed 16-bit source into a 4-slot ring
        load_cfg(32'h100, 32'h2000, 16'd0, 16'd2, 2'd1, 2'd1, 16'd2,
                 32'd0, -32'sd8, 10'd4);

        // R2: clear beats set in the same cycle; requests dropped while clear
        cur_tag = "R2";
        @(negedge clk); erq_set = 1'b1; erq_clr = 1'b1;
        @(negedge clk); erq_set = 1'b0; erq_clr = 1'b0;
        check("R2 erq set+clr", {31'b0, erq}, 32'd0);
        pulse_req();
        repeat (10) @(negedge clk);
        check("R2 dropped request leaves done", {31'b0, done}, 32'd0);
        @(negedge clk); erq_set = 1'b1;
        @(negedge clk); erq_set = 1'b0;
        check("R2 erq set", {31'b0, erq}, 32'd1);

        // R11 / R5 / R6: ring walk and wrap
        cur_tag = "R11";
        for (int i = 0; i < 3; i++) serve_one();
        check("R5 done before pass end", {31'b0, done}, 32'd0);
        serve_one();
        check("R5 done at pass end", {31'b0, done}, 32'd1);
        serve_one();   // writes slot 0x2000 again
        check("R6 done sticky", {31'b0, done}, 32'd1);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        check("R6 done cleared", {31'b0, done}, 32'd0);

        // R3: byte reads packed into 32-bit writes
        cur_tag = "R3 pack";
        load_cfg(32'h300, 32'h4000, 16'd1, 16'd4, 2'd0, 2'd2, 16'd8,
                 -32'sd16, -32'sd16, 10'd2);
        for (int i = 0; i < 3; i++) serve_one();
        check("R5 done after 2-loop pass", {31'b0, done}, 32'd1);

        // R9: reload clears done and restarts addresses
        load_cfg(32'h500, 32'h600, 16'hFFFC, 16'd1, 2'd2, 2'd0, 16'd8,
                 32'd0, 32'd0, 10'd3);
        check("R9 done cleared by load", {31'b0, done}, 32'd0);

        // R4: negative source step, word read split into byte writes
        cur_tag = "R4 split";
        serve_one();
        check("R4 done mid pass", {31'b0, done}, 32'd0);

        // R7: requests during a busy loop collapse into one
        cur_tag = "R7";
        load_cfg(32'h100, 32'h2000, 16'd0, 16'd2, 2'd1, 2'd1, 16'd2,
                 32'd0, -32'sd8, 10'd4);
        stall = 2;
        pulse_req();
        predict_loop();
        pulse_req();
        pulse_req();
        predict_loop();
        wait_quiet();
        repeat (10) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 32'd0);
        stall = 0;

        // R8: misaligned source rejected, no access, further requests ignored
        cur_tag = "R8";
        load_cfg(32'h101, 32'h2000, 16'd0, 16'd2, 2'd1, 2'd1, 16'd2,
                 32'd0, 32'd0, 10'd4);
        pulse_req();
        repeat (8) @(negedge clk);
        check("R8 err after misaligned start", {31'b0, err}, 32'd1);
        pulse_req();
        repeat (8) @(negedge clk);
        check("R8 err held, no access", {31'b0, err}, 32'd1);
        load_cfg(32'h100, 32'h2000, 16'd0, 16'd2, 2'd1, 2'd3, 16'd2,
                 32'd0, 32'd0, 10'd4);
        check("R9 err cleared by load", {31'b0, err}, 32'd0);
        pulse_req();
        repeat (8) @(negedge clk);
        check("R8 err on illegal size code", {31'b0, err}, 32'd1);

        // R9: aligned reload serves again
        cur_tag = "R9";
        load_cfg(32'h100, 32'h2000, 16'd0, 16'd2, 2'd1, 2'd1, 16'd2,
                 32'd0, -32'sd8, 10'd1);
        serve_one();
        check("R9 single-loop pass sets done", {31'b0, done}, 32'd1);
        check("R9 no error", {31'b0, err}, 32'd0);

        summary();
        $finish;
    end

endmodule